// File: doc/BRIEF.md
# External Interrupt Detector

This block watches one dedicated interrupt line and a small group of general pins, and turns what it sees into interrupt flags and a wake request for a small microcontroller. The dedicated line has a 2-bit sense setting: low level, any change, falling edge or rising edge. The general pins form one pin-change group. A toggle on any pin whose mask bit is set raises a single shared flag. The pins are read as they are, so software that drives a pin as an output can raise its own interrupt.

Edge detection on the dedicated line runs only while the I/O clock is marked as running (`io_clk_en`). Low-level and pin-change detection do not need it, so either can wake the device from deep sleep. The `wake_req` output is driven from the raw dedicated pin with no clocked stage in between.

After a sleep, a level interrupt counts only if the level is still low when the start-up period ends. The sleep controller marks that moment with a pulse on `start_up_done`. If the level has gone by then, the device wakes but no flag is set.

Software writes three locations through a write strobe, an address and data. Flags are cleared by an acknowledge input or by writing a one to the clear location. Each flag reaches its request output only when its enable bit is set.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, `xirq_flag`, `chg_flag`, `xirq_req`, `chg_req` and `wake_req` are all 0. The sense setting is low level, both enables are 0 and the mask is 0.
- R2: A write to address 0 loads the control bits:
  - bits [1:0] are the sense setting, encoded 00 low level, 01 any change, 10 falling, 11 rising;
  - bit 2 enables the dedicated request;
  - bit 3 enables the pin-change request.

  A write to address 1 loads the mask from bits [3:0]. A write to address 3 changes no state.
- R3: In an edge setting, with `io_clk_en` high, a qualifying transition on `xirq_pin` sets `xirq_flag`. The flag is visible after the third rising clock edge that follows the transition. A transition of the other direction sets nothing in the rising or falling setting.
- R4: In an edge setting, `xirq_flag` stays set until one of two things happens: `xirq_ack` is high at a clock edge, or a write to address 2 has bit 0 set. If a new edge arrives in the same cycle as a clear, the flag stays set.
- R5: While `io_clk_en` is low, no edge on `xirq_pin` is detected. An edge that happened while it was low is not reported after it returns high.
- R6: In the low-level setting, `xirq_flag` is 1 exactly while the synchronized pin is low (two clock edges of lag). Acknowledge and clear have no effect while the level lasts.
- R7: When the sense setting is low level, the dedicated enable is set and `xirq_pin` is low, `wake_req` is 1 at once, whatever the state of `io_clk_en`.
- R8: A low `io_clk_en` at a clock edge closes the level flag. It reopens only at a clock edge where `io_clk_en` and `start_up_done` are both high. If the pin has returned high by then, the result is wake only and no flag.
- R9: A toggle in either direction on a `chg_pins` bit whose mask bit is 1 sets `chg_flag` after the third following clock edge, whether or not `io_clk_en` is high. Unmasked pins have no effect. The flag is cleared by `chg_ack`, or by a write to address 2 with bit 1 set.
- R10: `xirq_req` is `xirq_flag` gated by the dedicated enable, and `chg_req` is `chg_flag` gated by the pin-change enable. Flags still record events while their enable is 0. `wake_req` is also high while `chg_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_clk_en | input | 1 | High while the I/O clock runs |
| xirq_pin | input | 1 | Dedicated interrupt pin |
| chg_pins | input | NPC | Pin-change inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| xirq_ack | input | 1 | Acknowledge for the dedicated flag |
| chg_ack | input | 1 | Acknowledge for the pin-change flag |
| start_up_done | input | 1 | Pulse marking the end of start-up |
| xirq_flag | output | 1 | Dedicated interrupt flag |
| chg_flag | output | 1 | Pin-change flag |
| xirq_req | output | 1 | Enabled dedicated request |
| chg_req | output | 1 | Enabled pin-change request |
| wake_req | output | 1 | Clock-independent wake request |

## Verification
The hardest case to reach is a wake from a low level when the level must be judged at the end of start-up. It needs an ordered sequence through the ports:
- drop `io_clk_en`;
- pull the pin low and see `wake_req` rise with no flag;
- restore the clock and confirm the flag stays closed;
- pulse `start_up_done`.

The stimulus then repeats this with the pin released before the pulse, to show the wake-only outcome. Edges and pin toggles during a halted clock, and an edge that lands in the same cycle as an acknowledge, are driven the same way. A behavioural model in the bench follows every cycle.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CLR  = 2'd2;

  // Packed so that bits [1:0] hold sense, bit 2 the dedicated enable, bit 3 the group enable
  typedef struct packed {
    logic   en_chg;
    logic   en_x;
    sense_e sense;
  } ctrl_t;

endpackage

// File: rtl/ext_irq_sync.sv
`timescale 1ns/1ps
module ext_irq_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/ext_irq_regs.sv
`timescale 1ns/1ps
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NPC    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output ctrl_t                 ctrl_q,
  output logic [NPC-1:0]        mask_q,
  output logic                  clr_x,
  output logic                  clr_chg
);

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int USED_W = (NPC > CTRL_W) ? NPC : CTRL_W;

  ctrl_t          ctrl_d;
  logic [NPC-1:0] mask_d;
  logic           ctrl_en;
  logic           mask_en;

  always_comb begin
    ctrl_en = wr && (addr == ADDR_CTRL);
    mask_en = wr && (addr == ADDR_MASK);
    ctrl_d  = ctrl_t'(wdata[CTRL_W-1:0]);
    mask_d  = wdata[NPC-1:0];
    clr_x   = wr && (addr == ADDR_CLR) && wdata[0];
    clr_chg = wr && (addr == ADDR_CLR) && wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:USED_W];

endmodule

// File: rtl/ext_irq_xdet.sv
`timescale 1ns/1ps
module ext_irq_xdet
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   io_clk_en,
  input  logic   pin_s,
  input  sense_e sense,
  input  logic   clr,
  input  logic   start_up_done,
  output logic   flag,
  output logic   lvl_open
);

  logic prev_q;
  logic sticky_q, sticky_d;
  logic open_q, open_d;
  logic rise, fall, hit;

  always_comb begin
    rise = pin_s & ~prev_q;
    fall = ~pin_s & prev_q;
    unique case (sense)
      SENSE_ANY:  hit = rise | fall;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      default:    hit = 1'b0;
    endcase
    // Edge detection exists only while the I/O clock runs; a new edge beats a clear
    sticky_d = (io_clk_en & hit) | (sticky_q & ~clr);
    // Level gate: shut by a halted I/O clock, reopened at the end of start-up
    open_d = open_q;
    if (!io_clk_en)         open_d = 1'b0;
    else if (start_up_done) open_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b1;
      sticky_q <= 1'b0;
      open_q   <= 1'b1;
    end else begin
      prev_q   <= pin_s;
      sticky_q <= sticky_d;
      open_q   <= open_d;
    end
  end

  assign flag     = (sense == SENSE_LOW) ? (open_q & ~pin_s) : sticky_q;
  assign lvl_open = open_q;

endmodule

// File: rtl/ext_irq_chgdet.sv
`timescale 1ns/1ps
module ext_irq_chgdet #(
  parameter int NPC = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NPC-1:0] pins_s,
  input  logic [NPC-1:0] mask,
  input  logic           clr,
  output logic           flag
);

  logic [NPC-1:0] prev_q;
  logic           flag_q, flag_d;
  logic           evt;

  always_comb begin
    evt    = |((pins_s ^ prev_q) & mask);
    flag_d = evt | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= pins_s;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/ext_irq_unit.sv
`timescale 1ns/1ps
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int NPC    = 4,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_clk_en,
  input  logic                  xirq_pin,
  input  logic [NPC-1:0]        chg_pins,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  xirq_ack,
  input  logic                  chg_ack,
  input  logic                  start_up_done,
  output logic                  xirq_flag,
  output logic                  chg_flag,
  output logic                  xirq_req,
  output logic                  chg_req,
  output logic                  wake_req
);

  ctrl_t          ctrl_w;
  logic [NPC-1:0] mask_w;
  logic           clr_x_wr, clr_chg_wr;
  logic           xpin_s;
  logic [NPC-1:0] chg_s;
  logic           lvl_open_w;
  logic           xflag_w, chgflag_w;
  sense_e         sense_w;
  logic           en_x_w, en_chg_w;

  ext_irq_regs #(.DATA_W(DATA_W), .NPC(NPC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_q(ctrl_w), .mask_q(mask_w), .clr_x(clr_x_wr), .clr_chg(clr_chg_wr)
  );

  ext_irq_sync #(.W(1), .RST_VAL(1'b1)) u_xsync (
    .clk(clk), .rst_n(rst_n), .d(xirq_pin), .q(xpin_s)
  );

  ext_irq_sync #(.W(NPC), .RST_VAL('0)) u_csync (
    .clk(clk), .rst_n(rst_n), .d(chg_pins), .q(chg_s)
  );

  assign sense_w  = ctrl_w.sense;
  assign en_x_w   = ctrl_w.en_x;
  assign en_chg_w = ctrl_w.en_chg;

  ext_irq_xdet u_xdet (
    .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en), .pin_s(xpin_s),
    .sense(sense_w), .clr(clr_x_wr | xirq_ack), .start_up_done(start_up_done),
    .flag(xflag_w), .lvl_open(lvl_open_w)
  );

  ext_irq_chgdet #(.NPC(NPC)) u_chg (
    .clk(clk), .rst_n(rst_n), .pins_s(chg_s), .mask(mask_w),
    .clr(clr_chg_wr | chg_ack), .flag(chgflag_w)
  );

  always_comb begin
    xirq_flag = xflag_w;
    chg_flag  = chgflag_w;
    xirq_req  = en_x_w & xflag_w;
    chg_req   = en_chg_w & chgflag_w;
    // Raw-pin level term keeps the wake path free of any clock
    wake_req  = ((sense_w == SENSE_LOW) & en_x_w & ~xirq_pin) | chg_req;
  end

endmodule

// File: rtl/ext_irq_unit_chk.sv
`timescale 1ns/1ps
module ext_irq_unit_chk #(
  parameter int NPC = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           io_clk_en,
  input logic           xirq_pin,
  input logic           reg_wr,
  input logic           xirq_ack,
  input logic           chg_ack,
  input logic [1:0]     sense,
  input logic           en_x,
  input logic           en_chg,
  input logic [NPC-1:0] mask,
  input logic           xirq_flag,
  input logic           chg_flag,
  input logic           xirq_req,
  input logic           chg_req,
  input logic           wake_req
);

  assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sense != 2'b00 && xirq_flag && !xirq_ack && !reg_wr) |=> xirq_flag);

  assert_no_edge_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sense != 2'b00 && !xirq_flag && !io_clk_en && !reg_wr) |=> !xirq_flag);

  assert_level_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == 2'b00 && en_x && !xirq_pin) |-> wake_req);

  assert_halt_closes_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_clk_en |=> (sense != 2'b00 || !xirq_flag));

  assert_chg_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !chg_ack && !reg_wr) |=> chg_flag);

  assert_chg_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0 && !chg_flag && !reg_wr) |=> !chg_flag);

  assert_xreq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_x |-> !xirq_req);

  assert_chgreq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_chg |-> !chg_req);

endmodule

bind ext_irq_unit ext_irq_unit_chk #(.NPC(NPC)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en), .xirq_pin(xirq_pin),
  .reg_wr(reg_wr), .xirq_ack(xirq_ack), .chg_ack(chg_ack),
  .sense(sense_w), .en_x(en_x_w), .en_chg(en_chg_w), .mask(mask_w),
  .xirq_flag(xirq_flag), .chg_flag(chg_flag), .xirq_req(xirq_req),
  .chg_req(chg_req), .wake_req(wake_req)
);

// File: tb/ext_irq_unit_tb_top.sv
`timescale 1ns/1ps
module ext_irq_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_clk_en = 1'b1;
  logic       xirq_pin = 1'b1;
  logic [3:0] chg_pins = 4'b0000;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       xirq_ack = 1'b0;
  logic       chg_ack = 1'b0;
  logic       start_up_done = 1'b0;
  logic       xirq_flag, chg_flag, xirq_req, chg_req, wake_req;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .io_clk_en(io_clk_en), .xirq_pin(xirq_pin),
    .chg_pins(chg_pins), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .xirq_ack(xirq_ack), .chg_ack(chg_ack), .start_up_done(start_up_done),
    .xirq_flag(xirq_flag), .chg_flag(chg_flag), .xirq_req(xirq_req),
    .chg_req(chg_req), .wake_req(wake_req)
  );

  // ---------------- behavioural reference ----------------
  bit       m_xh[$];
  bit [3:0] m_ch[$];
  bit [1:0] m_sense;
  bit       m_enx, m_enc, m_fx, m_fc, m_open;
  bit [3:0] m_mask;

  task automatic model_reset();
    m_xh = '{1'b1, 1'b1, 1'b1};
    m_ch = '{4'b0, 4'b0, 4'b0};
    m_sense = 2'b00; m_enx = 0; m_enc = 0; m_mask = 4'b0;
    m_fx = 0; m_fc = 0; m_open = 1;
  endtask

  task automatic model_step();
    bit now_s, old_s, ev, clrx, clrc;
    bit [3:0] c_now, c_old;
    now_s = m_xh[1]; old_s = m_xh[2];
    c_now = m_ch[1]; c_old = m_ch[2];
    clrx = xirq_ack || (reg_wr && reg_addr == 2'd2 && reg_wdata[0]);
    clrc = chg_ack  || (reg_wr && reg_addr == 2'd2 && reg_wdata[1]);
    case (m_sense)
      2'b01: ev = (now_s != old_s);
      2'b10: ev = old_s && !now_s;
      2'b11: ev = !old_s && now_s;
      default: ev = 0;
    endcase
    ev = ev && io_clk_en;
    m_fx = ev || (m_fx && !clrx);
    m_fc = (((c_now ^ c_old) & m_mask) != 0) || (m_fc && !clrc);
    if (!io_clk_en) m_open = 0;
    else if (start_up_done) m_open = 1;
    if (reg_wr && reg_addr == 2'd0) begin
      m_sense = reg_wdata[1:0]; m_enx = reg_wdata[2]; m_enc = reg_wdata[3];
    end
    if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata[3:0];
    m_xh.push_front(xirq_pin); void'(m_xh.pop_back());
    m_ch.push_front(chg_pins); void'(m_ch.pop_back());
  endtask

  function automatic bit exp_xflag();
    return (m_sense == 2'b00) ? (m_open && !m_xh[1]) : m_fx;
  endfunction

  function automatic bit exp_wake();
    return ((m_sense == 2'b00) && m_enx && !xirq_pin) || (m_enc && m_fc);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R3 R4 R6 R8 xirq_flag", xirq_flag, exp_xflag());
      chk("R9 chg_flag", chg_flag, m_fc);
      chk("R10 xirq_req", xirq_req, m_enx && exp_xflag());
      chk("R10 chg_req", chg_req, m_enc && m_fc);
      chk("R7 wake_req", wake_req, exp_wake());
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 xirq_flag", xirq_flag, 0);
    chk("R1 chg_flag", chg_flag, 0);
    chk("R1 xirq_req", xirq_req, 0);
    chk("R1 chg_req", chg_req, 0);
    chk("R1 wake_req", wake_req, 0);

    // R2 / R3 rising setting with dedicated enable
    wr(2'd0, 8'h07);
    xirq_pin = 0; tick(4);
    chk("R3 fall ignored in rise", xirq_flag, 0);
    xirq_pin = 1; tick(2);
    chk("R3 not before third edge", xirq_flag, 0);
    tick();
    chk("R3 rise sets flag", xirq_flag, 1);
    chk("R10 enabled request", xirq_req, 1);

    // R2 address 3 has no effect
    wr(2'd3, 8'hFF);
    chk("R2 addr3 ignored", xirq_flag, 1);

    // R4 acknowledge and W1C
    xirq_ack = 1; tick(); xirq_ack = 0;
    chk("R4 ack clears", xirq_flag, 0);
    xirq_pin = 0; tick(3);
    xirq_pin = 1; tick(2);
    xirq_ack = 1; tick(); xirq_ack = 0;
    chk("R4 set wins over clear", xirq_flag, 1);
    wr(2'd2, 8'h01);
    chk("R4 write-one clears", xirq_flag, 0);

    // R3 falling and any-change settings
    wr(2'd0, 8'h06);
    xirq_pin = 0; tick(3);
    chk("R3 fall sets flag", xirq_flag, 1);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h05);
    xirq_pin = 1; tick(3);
    chk("R3 any rise", xirq_flag, 1);
    wr(2'd2, 8'h01);
    xirq_pin = 0; tick(3);
    chk("R3 any fall", xirq_flag, 1);
    wr(2'd2, 8'h01);

    // R5 no edge while I/O clock halted
    wr(2'd0, 8'h07);
    io_clk_en = 0; xirq_pin = 1; tick(5);
    chk("R5 halted edge", xirq_flag, 0);
    io_clk_en = 1; tick(5);
    chk("R5 no late edge", xirq_flag, 0);
    start_up_done = 1; tick(); start_up_done = 0;

    // R6 low level setting
    wr(2'd0, 8'h04);
    xirq_pin = 0; tick();
    chk("R6 level lag", xirq_flag, 0);
    tick();
    chk("R6 level flag", xirq_flag, 1);
    xirq_ack = 1; tick(); xirq_ack = 0;
    chk("R6 ack no effect", xirq_flag, 1);
    wr(2'd2, 8'h01);
    chk("R6 clear no effect", xirq_flag, 1);
    xirq_pin = 1; tick(2);
    chk("R6 level released", xirq_flag, 0);

    // R7 / R8 wake with level held through start-up
    io_clk_en = 0; tick(2);
    xirq_pin = 0; #1;
    chk("R7 async wake", wake_req, 1);
    tick(4);
    chk("R8 no flag asleep", xirq_flag, 0);
    io_clk_en = 1; tick(4);
    chk("R8 no flag before start-up end", xirq_flag, 0);
    start_up_done = 1; tick(); start_up_done = 0;
    chk("R8 flag after start-up", xirq_flag, 1);
    chk("R8 request after start-up", xirq_req, 1);

    // R8 level gone before start-up ends
    xirq_pin = 1; tick(3);
    io_clk_en = 0; tick();
    xirq_pin = 0; #1;
    chk("R7 wake second", wake_req, 1);
    tick(2);
    xirq_pin = 1; tick(2);
    io_clk_en = 1; tick(2);
    start_up_done = 1; tick(); start_up_done = 0;
    tick(2);
    chk("R8 wake only no flag", xirq_flag, 0);
    chk("R8 wake dropped", wake_req, 0);

    // R9 / R10 pin-change group
    wr(2'd0, 8'h08);
    chg_pins = 4'b0001; tick(4);
    chk("R9 zero mask", chg_flag, 0);
    wr(2'd1, 8'h05);
    chg_pins = 4'b0101; tick(2);
    chk("R9 not before third edge", chg_flag, 0);
    tick();
    chk("R9 rise sets", chg_flag, 1);
    chk("R10 group request", chg_req, 1);
    chk("R10 group wake", wake_req, 1);
    chg_ack = 1; tick(); chg_ack = 0;
    chk("R9 ack clears", chg_flag, 0);
    chg_pins = 4'b0100; tick(3);
    chk("R9 fall sets", chg_flag, 1);
    wr(2'd2, 8'h02);
    chk("R9 write-one clears", chg_flag, 0);
    chg_pins = 4'b0110; tick(4);
    chk("R9 unmasked ignored", chg_flag, 0);
    io_clk_en = 0; chg_pins = 4'b0010; tick(3);
    chk("R9 async toggle", chg_flag, 1);
    io_clk_en = 1;
    wr(2'd0, 8'h00);
    chk("R10 flag kept", chg_flag, 1);
    chk("R10 request gated", chg_req, 0);
    chk("R10 no wake", wake_req, 0);
    chg_ack = 1; tick(); chg_ack = 0;

    // R10 dedicated flag records while disabled
    wr(2'd0, 8'h03);
    xirq_pin = 0; tick(3);
    xirq_pin = 1; tick(3);
    chk("R10 flag while disabled", xirq_flag, 1);
    chk("R10 request off", xirq_req, 0);
    wr(2'd2, 8'h01);
    tick(2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule